// File: doc/BRIEF.md
# Lockable Two-Stage Watchdog Timer

This block is a free-running watchdog counter with two staged limits. When the running count reaches the first limit, a sticky interrupt status bit sets and drives an interrupt output. When the count reaches the second limit, the block raises a reset request, which a reset controller outside the block acts on. Software keeps the watchdog from firing by writing a fresh value into the count register before the limits are reached.

The enable, the sleep-pause option and both limits can be frozen by a one-way lock bit. The lock bit comes out of reset open. Writing 0 closes it, and only a reset opens it again. The count register stays writable while locked, so servicing the watchdog keeps working after the configuration is frozen. If the sleep-pause option is on, the counter holds while the sleep input is high.

All access goes through a simple word-addressed register port. A write takes effect on the clock edge where `regWe` is high. Read data is combinational from `regAddr`.

Top module: `bark_bite_wdog`

## Requirements
- R1: Register word addresses are lock=0, control=1, first limit=2, second limit=3, count=4, status=5, test=6. Lock bit 0 reads 1 after reset. Writing 0 to it clears it. Once cleared, a later write of 1 leaves it at 0.
- R2: While the lock bit is 0, writes to control, first limit and second limit are ignored, and their read values do not change.
- R3: Control bit 0 is enable and bit 1 is pause-in-sleep. After reset, control, both limits, count, status, `barkIrq` and `biteReq` are all 0.
- R4: While enable is 1, the count goes up by 1 on every clock edge. While enable is 0, the count holds.
- R5: With pause-in-sleep set, the count holds on each edge where `sleepIn` is 1. With pause-in-sleep clear, `sleepIn` has no effect.
- R6: Status bit 0, which is also the `barkIrq` output, sets on the edge after an enabled count is >= the first limit. Writing a 1 to status bit 0 clears it. If a clear and a set happen on the same edge, the set wins.
- R7: `biteReq` is 1 in the cycle after an enabled count is >= the second limit. It returns to 0 one edge after that condition stops holding.
- R8: A count write loads the written value even while locked. On the same edge it takes priority over the increment.
- R9: Writing a 1 to test bit 0 sets status bit 0 and `barkIrq` regardless of the count.
- R10: While enable is 0, neither limit comparison sets status or `biteReq`. This holds even when both limits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word address |
| regWdata | input | CNT_W | Write data |
| regRdata | output | CNT_W | Read data for regAddr |
| sleepIn | input | 1 | Sleep indication |
| barkIrq | output | 1 | First-stage interrupt |
| biteReq | output | 1 | Second-stage reset request |

## Verification
The properties assume a single synchronous master. They also assume that a write to the count address is visible at the ports in the cycle it lands, so that the checker can exclude that cycle from the step and hold properties. The stimulus drives the register port and `sleepIn` only between edges and holds each write for exactly one cycle. It sweeps small limits from 0 to 5 so that every comparison boundary is crossed while the count stays far from wraparound. Sleep patterns are periodic, which lets the bench compute the expected count arithmetically.

// File: rtl/bbw_pkg.sv
package bbw_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADR_LOCK  = 3'd0,
    ADR_CTRL  = 3'd1,
    ADR_BARK  = 3'd2,
    ADR_BITE  = 3'd3,
    ADR_COUNT = 3'd4,
    ADR_STAT  = 3'd5,
    ADR_TEST  = 3'd6
  } regAddr_e;

  localparam int CTRL_EN_BIT    = 0;
  localparam int CTRL_PAUSE_BIT = 1;

  typedef struct packed {
    logic cntLoad;
    logic statClr;
    logic statForce;
  } dpStrobe_t;
endpackage

// File: rtl/bbw_ctrl.sv
module bbw_ctrl
  import bbw_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CNT_W-1:0]  regWdata,
  input  logic [CNT_W-1:0]  cntValue,
  input  logic              statBit,
  output logic [CNT_W-1:0]  regRdata,
  output logic              lockOpen,
  output logic              cfgEnable,
  output logic              cfgPause,
  output logic [CNT_W-1:0]  barkThr,
  output logic [CNT_W-1:0]  biteThr,
  output dpStrobe_t         strobe
);
  localparam logic [CNT_W-1:0] ZERO_W = '0;

  logic wrLock, wrCtrl, wrBark, wrBite, cfgWrOk;

  always_comb begin
    wrLock  = regWe && (regAddr == ADR_LOCK);
    cfgWrOk = regWe && lockOpen;
    wrCtrl  = cfgWrOk && (regAddr == ADR_CTRL);
    wrBark  = cfgWrOk && (regAddr == ADR_BARK);
    wrBite  = cfgWrOk && (regAddr == ADR_BITE);
    strobe.cntLoad   = regWe && (regAddr == ADR_COUNT);
    strobe.statClr   = regWe && (regAddr == ADR_STAT) && regWdata[0];
    strobe.statForce = regWe && (regAddr == ADR_TEST) && regWdata[0];
  end

  // one-way lock: only a write of 0 moves it, and only toward closed
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockOpen <= 1'b1;
    end else if (wrLock && !regWdata[0]) begin
      lockOpen <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgEnable <= 1'b0;
      cfgPause  <= 1'b0;
    end else if (wrCtrl) begin
      cfgEnable <= regWdata[CTRL_EN_BIT];
      cfgPause  <= regWdata[CTRL_PAUSE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      barkThr <= '0;
    end else if (wrBark) begin
      barkThr <= regWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      biteThr <= '0;
    end else if (wrBite) begin
      biteThr <= regWdata;
    end
  end

  always_comb begin
    regRdata = ZERO_W;
    unique case (regAddr)
      ADR_LOCK:  regRdata[0] = lockOpen;
      ADR_CTRL: begin
        regRdata[CTRL_EN_BIT]    = cfgEnable;
        regRdata[CTRL_PAUSE_BIT] = cfgPause;
      end
      ADR_BARK:  regRdata = barkThr;
      ADR_BITE:  regRdata = biteThr;
      ADR_COUNT: regRdata = cntValue;
      ADR_STAT:  regRdata[0] = statBit;
      default:   regRdata = ZERO_W;
    endcase
  end
endmodule

// File: rtl/bbw_datapath.sv
module bbw_datapath
  import bbw_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [CNT_W-1:0] loadValue,
  input  logic             cfgEnable,
  input  logic             cfgPause,
  input  logic             sleepIn,
  input  logic [CNT_W-1:0] barkThr,
  input  logic [CNT_W-1:0] biteThr,
  output logic [CNT_W-1:0] cntValue,
  output logic             statBit,
  output logic             biteReq
);
  localparam logic [CNT_W-1:0] ONE_W = CNT_W'(1);

  logic advance, barkHit, biteHit;

  always_comb begin
    advance = cfgEnable && !(cfgPause && sleepIn);
    barkHit = cfgEnable && (cntValue >= barkThr);
    biteHit = cfgEnable && (cntValue >= biteThr);
  end

  // software load outranks the increment
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntValue <= '0;
    end else if (strobe.cntLoad) begin
      cntValue <= loadValue;
    end else if (advance) begin
      cntValue <= cntValue + ONE_W;
    end
  end

  // set sources win over the clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statBit <= 1'b0;
    end else begin
      statBit <= (statBit && !strobe.statClr) || barkHit || strobe.statForce;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      biteReq <= 1'b0;
    end else begin
      biteReq <= biteHit;
    end
  end
endmodule

// File: rtl/bark_bite_wdog.sv
module bark_bite_wdog
  import bbw_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CNT_W-1:0]  regWdata,
  output logic [CNT_W-1:0]  regRdata,
  input  logic              sleepIn,
  output logic              barkIrq,
  output logic              biteReq
);
  dpStrobe_t        strobe;
  logic             lockOpen, cfgEnable, cfgPause, statBit;
  logic [CNT_W-1:0] barkThr, biteThr, cntValue;

  bbw_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .cntValue(cntValue), .statBit(statBit),
    .regRdata(regRdata), .lockOpen(lockOpen), .cfgEnable(cfgEnable),
    .cfgPause(cfgPause), .barkThr(barkThr), .biteThr(biteThr),
    .strobe(strobe)
  );

  bbw_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .loadValue(regWdata),
    .cfgEnable(cfgEnable), .cfgPause(cfgPause), .sleepIn(sleepIn),
    .barkThr(barkThr), .biteThr(biteThr), .cntValue(cntValue),
    .statBit(statBit), .biteReq(biteReq)
  );

  assign barkIrq = statBit;
endmodule

// File: rtl/bbw_checker.sv
module bbw_checker
  import bbw_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic [ADDR_W-1:0] regAddr,
  input logic [CNT_W-1:0]  regWdata,
  input logic              sleepIn,
  input logic              lockOpen,
  input logic              cfgEnable,
  input logic              cfgPause,
  input logic [CNT_W-1:0]  barkThr,
  input logic [CNT_W-1:0]  biteThr,
  input logic [CNT_W-1:0]  cntValue,
  input logic              barkIrq,
  input logic              biteReq
);
  logic cntWr;
  assign cntWr = regWe && (regAddr == ADR_COUNT);

  a_r1_lock_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !lockOpen |=> !lockOpen);

  a_r2_cfg_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !lockOpen |=> ($stable(cfgEnable) && $stable(cfgPause) &&
                   $stable(barkThr) && $stable(biteThr)));

  a_r4_hold_off: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgEnable && !cntWr) |=> $stable(cntValue));

  a_r4_step: assert property (@(posedge clk) disable iff (!rstN)
    (cfgEnable && !(cfgPause && sleepIn) && !cntWr)
      |=> (cntValue == CNT_W'($past(cntValue) + CNT_W'(1))));

  a_r5_pause_hold: assert property (@(posedge clk) disable iff (!rstN)
    (cfgEnable && cfgPause && sleepIn && !cntWr) |=> $stable(cntValue));

  a_r6_bark_set: assert property (@(posedge clk) disable iff (!rstN)
    (cfgEnable && (cntValue >= barkThr)) |=> barkIrq);

  a_r7_bite_on: assert property (@(posedge clk) disable iff (!rstN)
    (cfgEnable && (cntValue >= biteThr)) |=> biteReq);

  a_r7_bite_off: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgEnable && (cntValue >= biteThr)) |=> !biteReq);

  a_r8_load_wins: assert property (@(posedge clk) disable iff (!rstN)
    cntWr |=> (cntValue == $past(regWdata)));
endmodule

bind bark_bite_wdog bbw_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
  .regWdata(regWdata), .sleepIn(sleepIn), .lockOpen(lockOpen),
  .cfgEnable(cfgEnable), .cfgPause(cfgPause), .barkThr(barkThr),
  .biteThr(biteThr), .cntValue(cntValue), .barkIrq(barkIrq),
  .biteReq(biteReq)
);

// File: tb/bark_bite_wdog_tb.sv
module bark_bite_wdog_tb;
  localparam int CNT_W = 32;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             regWe = 1'b0;
  logic [2:0]       regAddr = 3'd0;
  logic [CNT_W-1:0] regWdata = '0;
  logic [CNT_W-1:0] regRdata;
  logic             sleepIn = 1'b0;
  logic             barkIrq, biteReq;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bark_bite_wdog #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .sleepIn(sleepIn),
    .barkIrq(barkIrq), .biteReq(biteReq)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [CNT_W-1:0] act,
                     input logic [CNT_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // called just after a falling edge; the write lands on the next rising edge
  task automatic wr(input logic [2:0] a, input logic [CNT_W-1:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [CNT_W-1:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  logic [CNT_W-1:0] v;
  int expCnt;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R3 reset values
    rd(3'd0, v); chk("R1 lock reset", v, 1);
    rd(3'd1, v); chk("R3 ctrl reset", v, 0);
    rd(3'd2, v); chk("R3 bark reset", v, 0);
    rd(3'd3, v); chk("R3 bite reset", v, 0);
    rd(3'd4, v); chk("R3 count reset", v, 0);
    rd(3'd5, v); chk("R3 stat reset", v, 0);
    // R10: disabled, zero limits, nothing fires
    repeat (4) @(negedge clk);
    chk("R10 no bark when disabled", barkIrq, 0);
    chk("R10 no bite when disabled", biteReq, 0);
    rd(3'd4, v); chk("R4 hold when disabled", v, 0);

    // R6 R7 sweep of limits
    for (int b = 0; b < 6; b++) begin
      wr(3'd1, 0); wr(3'd4, 0); wr(3'd5, 1);
      wr(3'd2, CNT_W'(b)); wr(3'd3, CNT_W'(b + 2));
      wr(3'd1, 1);
      for (int n = 0; n <= b + 5; n++) begin
        rd(3'd4, v); chk("R4 step count", v, CNT_W'(n));
        chk("R6 bark timing", barkIrq, (n >= 1 && n - 1 >= b));
        chk("R7 bite timing", biteReq, (n >= 1 && n - 1 >= b + 2));
        @(negedge clk);
      end
    end

    // R6 set wins over clear (still enabled, count above limit)
    wr(3'd5, 1);
    chk("R6 set beats clear", barkIrq, 1);
    // R6 clear when disabled
    wr(3'd1, 0); wr(3'd5, 1);
    chk("R6 clear", barkIrq, 0);
    rd(3'd5, v); chk("R6 stat readback", v, 0);
    // R9 force
    wr(3'd6, 1);
    chk("R9 force irq", barkIrq, 1);
    rd(3'd5, v); chk("R9 force stat", v, 1);
    wr(3'd5, 1);

    // R5 pause with periodic sleep
    wr(3'd4, 0); wr(3'd3, 1000); wr(3'd1, 3);
    expCnt = 0;
    for (int i = 0; i < 12; i++) begin
      sleepIn = (i % 3 == 0);
      @(negedge clk);
      if (!sleepIn) expCnt++;
      rd(3'd4, v); chk("R5 pause count", v, CNT_W'(expCnt));
    end
    // R5 pause off: sleep ignored
    sleepIn = 1'b1;
    wr(3'd1, 0); wr(3'd4, 0); wr(3'd1, 1);
    repeat (5) @(negedge clk);
    rd(3'd4, v); chk("R5 sleep ignored", v, 5);
    sleepIn = 1'b0;

    // R8 load beats increment
    wr(3'd4, 100);
    rd(3'd4, v); chk("R8 load priority", v, 100);
    @(negedge clk);
    rd(3'd4, v); chk("R8 resume after load", v, 101);

    // R1 R2 lock
    wr(3'd1, 0); wr(3'd4, 0); wr(3'd2, 3); wr(3'd3, 5); wr(3'd1, 1);
    wr(3'd0, 0);
    rd(3'd0, v); chk("R1 lock cleared", v, 0);
    wr(3'd0, 1);
    rd(3'd0, v); chk("R1 lock sticky", v, 0);
    wr(3'd1, 0); rd(3'd1, v); chk("R2 ctrl locked", v, 1);
    wr(3'd2, 9); rd(3'd2, v); chk("R2 bark locked", v, 3);
    wr(3'd3, 9); rd(3'd3, v); chk("R2 bite locked", v, 5);
    // R8 kick while locked
    wr(3'd4, 0);
    rd(3'd4, v); chk("R8 load while locked", v, 0);
    repeat (7) @(negedge clk);
    chk("R7 bite asserted", biteReq, 1);
    wr(3'd4, 0);
    @(negedge clk);
    chk("R7 bite released after kick", biteReq, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule